// File: doc/BRIEF.md
# Shadow RAM Write Replay Bridge

This block couples a fast accelerator processor to a slow host memory bus that runs at roughly 1 MHz and that a video controller shares by stealing cycles. The processor reads and writes a small local shadow memory with no wait states. Every write that lands in ordinary memory is also stored in a replay queue. The queue drains onto the host bus, one write per idle host cycle, so the host copy stays coherent and video fetches are never disturbed.

Accesses to the host I/O window cannot be served locally. Timer and sprite registers there must see traffic at host pace and in program order. An I/O access therefore first waits until the replay queue is empty and then runs on the host bus in the next idle slot. A turbo-off input sends every access down that same host path for cycle-exact behaviour. A speed selector paces local accesses at 1x, 5x or 20x of the host rate.

The idle-slot input is a one-clock pulse that the host side raises once per host cycle in which the bus is free. During a bad raster line it stays low for 40 host cycles.

Top module: `shadow_replay_bridge`

## Requirements
- R1: After reset the replay queue is empty: no host transaction is issued, whatever `host_slot` does, until a write is accepted, and `cpu_ready` stays low while `cpu_req` is low.
- R2: With `turbo_off` low and `speed_sel` at 20x, a request outside the I/O window completes (`cpu_ready` high) in the cycle it is presented, whether or not `host_slot` pulses. A read returns the last byte written to the same low `SHADOW_AW` address bits.
- R3: Each completed local write appears once on the host bus with `hb_we`=1 and the same address and data. Replays are issued in the order the writes completed.
- R4: A host transaction is issued only in a cycle where `host_slot` is high, and at most one per such cycle. No replay is issued during a stretch of 40 cycles without slots.
- R5: The replay queue holds 16 entries. A local write presented while 16 are pending is stalled, and it completes in the cycle after the first slot that drains an entry.
- R6: An access whose upper four address bits equal 0xD (I/O window 0xD000–0xDFFF) waits until every pending replay has been issued. It is then issued on the next `host_slot` after the queue empties, and it completes in the cycle after its issue.
- R7: An I/O read returns `hb_rdata` as driven in the cycle after its issue, never shadow contents. An I/O write leaves the shadow byte at the aliased low address unchanged.
- R8: With `turbo_off` high, every access, including ordinary memory, takes the host path of R6. Reads return host data, and writes also update the shadow memory.
- R9: `speed_sel` 2'b00 (1x) lets a local access complete at most once every 20 clocks, 2'b01 (5x) once every 4, and 2'b10 or 2'b11 (20x) every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| turbo_off | input | 1 | Force every access onto the host path |
| speed_sel | input | 2 | Local pacing: 00 1x, 01 5x, 1x 20x |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at this clock edge |
| host_slot | input | 1 | One-clock pulse per free host bus cycle |
| hb_valid | output | 1 | Host transaction issued this cycle |
| hb_we | output | 1 | Host transaction is a write |
| hb_addr | output | ADDR_W | Host transaction address |
| hb_wdata | output | DATA_W | Host write data |
| hb_rdata | input | DATA_W | Host read data, valid the cycle after issue |

## Verification
The bench leaves the queue loaded across a 40-cycle run without slots. A bridge that ignored slot timing would place writes on the bus in the middle of a video fetch. It fills the queue to exactly 16 and presents a seventeenth write, then frees one entry with a single slot. An off-by-one capacity would either accept the write early or hang on it. An I/O write is issued behind three pending replays with a known slot spacing and its completion cycle is checked, so a bridge that let I/O overtake the queue shows up as a reordered bus log and an early ready. The remaining tests look for shadow corruption by I/O writes, shadow reads leaking into I/O or turbo-off reads, and wrong pacing gaps at 1x and 5x.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;

    // Controller states of the bridge
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // serve local accesses, route others
        ST_DRAIN = 2'd1,   // host-path access waits for empty queue
        ST_HOST  = 2'd2,   // waiting for an idle host slot to issue
        ST_RESP  = 2'd3    // host result available, complete access
    } srb_state_e;

    // Speed selector encodings
    localparam logic [1:0] SPD_1X  = 2'b00;
    localparam logic [1:0] SPD_5X  = 2'b01;
    localparam logic [1:0] SPD_20X = 2'b10;

endpackage

// File: rtl/srb_pacer.sv
`timescale 1ns/1ps
module srb_pacer
    import srb_pkg::*;
#(
    parameter int HOST_RATIO = 20,
    parameter int MID_MULT   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] speed_sel,
    output logic       tick
);
    localparam int CW = $clog2(HOST_RATIO + 1);
    localparam logic [CW-1:0] RELOAD_1X  = CW'(HOST_RATIO - 1);
    localparam logic [CW-1:0] RELOAD_5X  = CW'(HOST_RATIO / MID_MULT - 1);
    localparam logic [CW-1:0] RELOAD_20X = '0;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;

    always_comb begin
        unique case (speed_sel)
            SPD_1X:  reload = RELOAD_1X;
            SPD_5X:  reload = RELOAD_5X;
            default: reload = RELOAD_20X;
        endcase
    end

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick)   cnt_q <= reload;
        else             cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/srb_fifo.sv
`timescale 1ns/1ps
module srb_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]      wr_ptr, rd_ptr;
    logic [CW-1:0]      used;
    logic [DEPTH*W-1:0] flat;
    logic               do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (used == '0);
    assign full    = (used == CW'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PW'(i)) ent_q <= push_data;
        end
        assign flat[i*W +: W] = ent_q;
    end

    assign pop_data = flat[rd_ptr*W +: W];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      used <= used + 1'b1;
            else if (do_pop && !do_push) used <= used - 1'b1;
        end
    end
endmodule

// File: rtl/srb_shadow.sv
`timescale 1ns/1ps
module srb_shadow #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // asynchronous read gives a zero-wait local access
    assign rdata = mem[raddr];
endmodule

// File: rtl/shadow_replay_bridge.sv
`timescale 1ns/1ps
module shadow_replay_bridge
    import srb_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int SHADOW_AW    = 8,
    parameter int FIFO_DEPTH   = 16,
    parameter int HOST_RATIO   = 20,
    parameter int MID_MULT     = 5,
    parameter int IO_SPAN_LOG2 = 12,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'hD000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              turbo_off,
    input  logic [1:0]        speed_sel,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              host_slot,
    output logic              hb_valid,
    output logic              hb_we,
    output logic [ADDR_W-1:0] hb_addr,
    output logic [DATA_W-1:0] hb_wdata,
    input  logic [DATA_W-1:0] hb_rdata
);
    localparam int ENT_W = ADDR_W + DATA_W;
    localparam int TAG_W = ADDR_W - IO_SPAN_LOG2;
    localparam logic [TAG_W-1:0] IO_TAG = IO_BASE[ADDR_W-1:IO_SPAN_LOG2];

    srb_state_e       state_q, state_d;
    logic             is_io, local_path;
    logic             pace_tick;
    logic             fifo_push, fifo_empty, fifo_full;
    logic [ENT_W-1:0] fifo_out;
    logic             rep_issue, direct_issue;
    logic             shadow_we;
    logic [DATA_W-1:0] shadow_rdata;

    assign is_io      = (cpu_addr[ADDR_W-1:IO_SPAN_LOG2] == IO_TAG);
    assign local_path = !is_io && !turbo_off;

    srb_pacer #(.HOST_RATIO(HOST_RATIO), .MID_MULT(MID_MULT)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .tick      (pace_tick)
    );

    srb_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data ({cpu_addr, cpu_wdata}),
        .pop       (rep_issue),
        .pop_data  (fifo_out),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    srb_shadow #(.AW(SHADOW_AW), .DW(DATA_W)) u_shadow (
        .clk   (clk),
        .we    (shadow_we),
        .waddr (cpu_addr[SHADOW_AW-1:0]),
        .wdata (cpu_wdata),
        .raddr (cpu_addr[SHADOW_AW-1:0]),
        .rdata (shadow_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req && !local_path) state_d = ST_DRAIN;
            ST_DRAIN: if (fifo_empty)             state_d = ST_HOST;
            ST_HOST:  if (host_slot)              state_d = ST_RESP;
            ST_RESP:                              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        cpu_ready    = 1'b0;
        shadow_we    = 1'b0;
        fifo_push    = 1'b0;
        direct_issue = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && local_path && pace_tick && !(cpu_we && fifo_full)) begin
                    cpu_ready = 1'b1;
                    shadow_we = cpu_we;
                    fifo_push = cpu_we;
                end
            end
            ST_DRAIN: ;
            ST_HOST:  direct_issue = host_slot;
            ST_RESP: begin
                cpu_ready = 1'b1;
                shadow_we = cpu_we && !is_io;
            end
            default: ;
        endcase
    end

    // replay engine: one pending write per idle host slot
    assign rep_issue = host_slot && !fifo_empty;

    assign hb_valid  = rep_issue || direct_issue;
    assign hb_we     = rep_issue ? 1'b1 : cpu_we;
    assign hb_addr   = rep_issue ? fifo_out[ENT_W-1:DATA_W] : cpu_addr;
    assign hb_wdata  = rep_issue ? fifo_out[DATA_W-1:0] : cpu_wdata;
    assign cpu_rdata = (state_q == ST_RESP) ? hb_rdata : shadow_rdata;
endmodule

// File: rtl/srb_checker.sv
`timescale 1ns/1ps
module srb_checker (
    input logic clk,
    input logic rst_n,
    input logic host_slot,
    input logic hb_valid,
    input logic hb_we,
    input logic rep_issue,
    input logic direct_issue,
    input logic fifo_full,
    input logic fifo_empty,
    input logic cpu_req,
    input logic cpu_we,
    input logic cpu_ready,
    input logic is_io,
    input logic turbo_off
);
    // R4: bus traffic only inside an idle host slot
    a_r4_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
        hb_valid |-> host_slot);

    // R3: replay and direct issue never share a slot
    a_r3_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rep_issue, direct_issue}));

    // R5: a local write with a full queue is held off
    a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !is_io && !turbo_off && fifo_full) |-> !cpu_ready);

    // R6: an I/O access only completes behind an empty queue
    a_r6_io_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && is_io) |-> fifo_empty);

    // R7: a host read completes one cycle after its issue
    a_r7_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_valid && !hb_we) |=> cpu_ready);
endmodule

bind shadow_replay_bridge srb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_slot    (host_slot),
    .hb_valid     (hb_valid),
    .hb_we        (hb_we),
    .rep_issue    (rep_issue),
    .direct_issue (direct_issue),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_ready    (cpu_ready),
    .is_io        (is_io),
    .turbo_off    (turbo_off)
);

// File: tb/shadow_replay_bridge_tb.sv
`timescale 1ns/1ps
module shadow_replay_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        turbo_off = 1'b0;
    logic [1:0]  speed_sel = 2'b10;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        host_slot = 1'b0;
    logic        hb_valid, hb_we;
    logic [15:0] hb_addr;
    logic [7:0]  hb_wdata;
    logic [7:0]  hb_rdata = '0;

    int n_chk = 0, n_fail = 0, cyc = 0, log_n = 0, slot_viol = 0;
    bit done = 0;
    logic [15:0] log_addr [0:255];
    logic [7:0]  log_data [0:255];
    logic        log_we   [0:255];

    always #2.5 clk = ~clk;

    shadow_replay_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .turbo_off(turbo_off), .speed_sel(speed_sel),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .host_slot(host_slot),
        .hb_valid(hb_valid), .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
        .hb_rdata(hb_rdata)
    );

    // host bus model and transaction log
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && hb_valid) begin
            log_addr[log_n] <= hb_addr;
            log_data[log_n] <= hb_wdata;
            log_we[log_n]   <= hb_we;
            log_n <= log_n + 1;
            if (!hb_we) hb_rdata <= hb_addr[7:0] ^ 8'h5A;
            if (!host_slot) slot_viol <= slot_viol + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_log(input int idx, input logic [15:0] a, input logic [7:0] d,
                             input bit we, input string tag);
        check(log_addr[idx] == a && log_we[idx] == we && (!we || log_data[idx] == d),
              tag, {log_addr[idx], log_data[idx]}, {a, d});
    endtask

    task automatic cpu_access(input logic [15:0] a, input bit we, input logic [7:0] d,
                              input int gap, input int hold,
                              output logic [7:0] rd, output int waited, output int rcyc);
        int sc = 0;
        waited = 0; rd = '0; rcyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            host_slot = (gap > 0 && sc >= hold && ((sc - hold) % gap) == 0);
            #2;
            if (cpu_ready) begin rd = cpu_rdata; rcyc = cyc; break; end
            waited++; sc++;
            if (waited > 3000) begin check(0, "access timeout", waited, 0); break; end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; host_slot = 1'b0;
    endtask

    task automatic drain(input int target, input int gap);
        int sc = 0;
        forever begin
            @(negedge clk);
            if (log_n >= target || sc > 2000) break;
            host_slot = ((sc % gap) == 0);
            sc++;
        end
        host_slot = 1'b0;
        check(log_n == target, "drain count", log_n, target);
    endtask

    task automatic t_reset_state();
        bit bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); host_slot = (i % 2 == 0); #2;
            if (cpu_ready || hb_valid) bad = 1;
        end
        @(negedge clk); host_slot = 1'b0;
        check(!bad && log_n == 0, "R1 quiet after reset", log_n, 0);
    endtask

    task automatic t_local_and_badline();
        logic [7:0] rd; int w, rc;
        for (int i = 0; i < 4; i++) begin
            cpu_access(16'h1000 * (i + 1) + 16'(i), 1, 8'hA0 + 8'(i), 0, 0, rd, w, rc);
            check(w == 0, "R2 zero-wait write", w, 0);
        end
        for (int i = 0; i < 4; i++) begin
            cpu_access(16'h1000 * (i + 1) + 16'(i), 0, 0, 0, 0, rd, w, rc);
            check(w == 0 && rd == 8'hA0 + 8'(i), "R2 shadow read", rd, 8'hA0 + 8'(i));
        end
        repeat (40) @(negedge clk);
        check(log_n == 0, "R4 no replay in bad line", log_n, 0);
        drain(4, 3);
        for (int i = 0; i < 4; i++)
            check_log(i, 16'h1000 * (i + 1) + 16'(i), 8'hA0 + 8'(i), 1, "R3 replay order");
    endtask

    task automatic t_queue_full();
        logic [7:0] rd; int w, rc, base;
        base = log_n;
        for (int i = 0; i < 16; i++) begin
            cpu_access(16'h0100 + 16'(i), 1, 8'h10 + 8'(i), 0, 0, rd, w, rc);
            check(w == 0, "R5 fill below capacity", w, 0);
        end
        cpu_access(16'h0110, 1, 8'h20, 1, 10, rd, w, rc);
        check(w == 11, "R5 stall until one drain", w, 11);
        drain(base + 17, 2);
        for (int i = 0; i < 17; i++)
            check_log(base + i, 16'h0100 + 16'(i), 8'h10 + 8'(i), 1, "R5 R3 full-queue order");
    endtask

    task automatic t_io_window();
        logic [7:0] rd; int w, rc, base;
        base = log_n;
        cpu_access(16'h0200, 1, 8'h31, 0, 0, rd, w, rc);
        cpu_access(16'h0201, 1, 8'h32, 0, 0, rd, w, rc);
        cpu_access(16'h0020, 1, 8'h11, 0, 0, rd, w, rc);
        cpu_access(16'hD020, 1, 8'h99, 3, 0, rd, w, rc);
        check(w == 10, "R6 I/O write waits for drain", w, 10);
        check(log_n == base + 4, "R6 log length", log_n, base + 4);
        check_log(base + 0, 16'h0200, 8'h31, 1, "R6 replay before I/O");
        check_log(base + 2, 16'h0020, 8'h11, 1, "R6 replay before I/O");
        check_log(base + 3, 16'hD020, 8'h99, 1, "R6 I/O write last");
        cpu_access(16'hD011, 0, 0, 1, 0, rd, w, rc);
        check(w == 3 && rd == 8'h4B, "R7 I/O read host data", rd, 8'h4B);
        check_log(base + 4, 16'hD011, 0, 0, "R7 I/O read on bus");
        cpu_access(16'h0020, 0, 0, 0, 0, rd, w, rc);
        check(rd == 8'h11, "R7 I/O write keeps shadow", rd, 8'h11);
    endtask

    task automatic t_turbo_off();
        logic [7:0] rd; int w, rc, base;
        base = log_n;
        turbo_off = 1'b1;
        cpu_access(16'h0040, 1, 8'h77, 1, 0, rd, w, rc);
        check(w == 3, "R8 turbo-off write on host path", w, 3);
        check_log(base, 16'h0040, 8'h77, 1, "R8 turbo-off write on bus");
        cpu_access(16'h0050, 0, 0, 1, 0, rd, w, rc);
        check(w == 3 && rd == 8'h0A, "R8 turbo-off read host data", rd, 8'h0A);
        turbo_off = 1'b0;
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, rc);
        check(w == 0 && rd == 8'h77, "R8 shadow updated", rd, 8'h77);
    endtask

    task automatic t_speed();
        logic [7:0] rd; int w, r1, r2, r3;
        speed_sel = 2'b01;
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r1);
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r2);
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r3);
        check(r3 - r2 == 4 && rd == 8'h77, "R9 5x pacing", r3 - r2, 4);
        speed_sel = 2'b00;
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r1);
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r2);
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r3);
        check(r3 - r2 == 20, "R9 1x pacing", r3 - r2, 20);
        speed_sel = 2'b10;
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r1);
        cpu_access(16'h0040, 0, 0, 0, 0, rd, w, r1);
        check(w == 0, "R9 20x every clock", w, 0);
    endtask

    initial begin
        #50000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        host_slot = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        host_slot = 1'b0;
        t_reset_state();
        t_local_and_badline();
        t_queue_full();
        t_io_window();
        t_turbo_off();
        t_speed();
        check(slot_viol == 0, "R4 issue outside slot", slot_viol, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule